// File: doc/BRIEF.md
# DMA Transfer Length Qualifier

This block sits between a storage-bus host controller's command sequencer and a block-oriented DMA engine. For each data phase it is handed the number of bytes the command expects, the direction, the command opcode, the fixed-length bit of the command, whether the target is a sequential-access (tape) device and whether the memory buffer lies outside the DMA engine's reach. It answers with the number of bytes the DMA engine may move. Whatever remains is left to programmed I/O.

The engine can only move whole 512-byte blocks when reading. Stopping it in the middle of a block would lose data. Reads are therefore admitted only when the length is a whole number of blocks and the command is known, or likely, to return whole blocks. Writes are always admitted, because the target stops accepting bytes when it has enough. Two hard ceilings then apply. The normal ceiling is 255 blocks. When the buffer is unreachable and the data must go through a small bounce area, the ceiling drops to 4096 bytes.

The answer is registered. It appears together with an output strobe one clock after the request strobe.

Top module: `dxq_qualifier`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_len` and `out_cut` change only in such cycles and otherwise keep their last value.
- R2: A write (`in_write`=1) is granted the full requested length, subject only to the ceiling of R8.
- R3: A read whose length is not a multiple of 512 (any of `in_len[8:0]` set) is granted 0 bytes.
- R4: The byte-mode read opcodes 0x37, 0x3E and 0x3C are granted 0 bytes on a read.
- R5: The block-mode read opcodes 0x08, 0x28, 0xA8, 0x0F and 0x14 are granted the full length on a read when the length is a whole number of blocks.
- R6: When `in_tape`=1 and `in_fixed`=0, a block-mode opcode is handled as byte-mode and granted 0. When `in_tape`=1 and `in_fixed`=1, it keeps its block-mode grant.
- R7: On a read with any other opcode and a whole-block length, the grant is 0 when the length is below 1024 and the full length otherwise.
- R8: The grant never exceeds 130560 bytes (255 × 512). When `in_unreach`=1 it never exceeds 4096 bytes. A length above the ceiling is granted exactly the ceiling.
- R9: `out_cut` is 1 exactly when the granted length differs from the requested length.
- R10: After reset, `out_valid`, `out_len` and `out_cut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one cycle per request |
| in_len | input | LEN_W | Requested transfer length in bytes |
| in_write | input | 1 | 1 = memory to device, 0 = device to memory |
| in_op | input | 8 | Command opcode byte |
| in_fixed | input | 1 | Bit 0 of the second command byte (fixed-length flag) |
| in_tape | input | 1 | Target is a sequential-access device |
| in_unreach | input | 1 | Buffer address is outside the DMA engine's reach |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_len | output | LEN_W | Length granted to the DMA engine |
| out_cut | output | 1 | Granted length differs from the requested length |

## Verification
The checker relates each registered result to the request sampled one cycle earlier. It therefore assumes that the request fields are meaningful whenever `in_valid` is high, and that `in_len` fits in `LEN_W` bits. It places no limit on how close together requests arrive. The bench drives every field only at falling clock edges. It holds each request for exactly one cycle and keeps lengths well inside the port width. It also issues requests back to back and with idle gaps in between, so that the hold and latency properties are exercised in both situations.

// File: rtl/dxq_pkg.sv
package dxq_pkg;

    typedef enum logic [1:0] {
        XC_UNKNOWN = 2'd0,
        XC_BLOCK   = 2'd1,
        XC_BYTE    = 2'd2
    } xfer_class_e;

    // Read commands that always move whole blocks
    localparam int N_BLOCK_OPS = 5;
    localparam logic [7:0] BLOCK_OPS [N_BLOCK_OPS] = '{
        8'h08,  // read, 6-byte form
        8'h28,  // read, 10-byte form
        8'hA8,  // read, 12-byte form
        8'h0F,  // reverse read
        8'h14   // fetch buffered data back
    };

    // Read commands whose returned byte count is not known in advance
    localparam int N_BYTE_OPS = 3;
    localparam logic [7:0] BYTE_OPS [N_BYTE_OPS] = '{
        8'h37,  // defect list read
        8'h3E,  // long sector read
        8'h3C   // buffer read
    };

    typedef struct packed {
        logic       write;
        logic [7:0] op;
        logic       fixed;
        logic       tape;
        logic       unreach;
    } req_attr_t;

    // A block command on a tape without the fixed bit moves a variable count
    function automatic logic demote_to_byte(input logic tape, input logic fixed);
        return tape && !fixed;
    endfunction

endpackage

// File: rtl/dxq_classify.sv
module dxq_classify
    import dxq_pkg::*;
(
    input  logic        [7:0] op,
    input  logic              tape,
    input  logic              fixed,
    output xfer_class_e       cls
);

    logic [N_BLOCK_OPS-1:0] blk_hit;
    logic [N_BYTE_OPS-1:0]  byte_hit;

    genvar gi;
    generate
        for (gi = 0; gi < N_BLOCK_OPS; gi++) begin : g_blk
            assign blk_hit[gi] = (op == BLOCK_OPS[gi]);
        end
        for (gi = 0; gi < N_BYTE_OPS; gi++) begin : g_byte
            assign byte_hit[gi] = (op == BYTE_OPS[gi]);
        end
    endgenerate

    always_comb begin
        if (|byte_hit) begin
            cls = XC_BYTE;
        end else if (|blk_hit) begin
            cls = demote_to_byte(tape, fixed) ? XC_BYTE : XC_BLOCK;
        end else begin
            cls = XC_UNKNOWN;
        end
    end

endmodule

// File: rtl/dxq_policy.sv
module dxq_policy
    import dxq_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int BLK_BYTES = 512,
    parameter int UNK_MIN   = 1024
) (
    input  logic        [LEN_W-1:0] len,
    input  logic                    write,
    input  xfer_class_e             cls,
    output logic        [LEN_W-1:0] allowed
);

    localparam int BLK_LOG = $clog2(BLK_BYTES);
    localparam logic [LEN_W-1:0] UNK_LIM = LEN_W'(UNK_MIN);

    logic partial_blk;
    assign partial_blk = |len[BLK_LOG-1:0];

    always_comb begin
        allowed = '0;
        if (write) begin
            allowed = len;
        end else if (!partial_blk) begin
            unique case (cls)
                XC_BLOCK:   allowed = len;
                XC_BYTE:    allowed = '0;
                default:    allowed = (len < UNK_LIM) ? '0 : len;
            endcase
        end
    end

endmodule

// File: rtl/dxq_cap.sv
module dxq_cap #(
    parameter int LEN_W      = 24,
    parameter int HARD_MAX   = 130560,
    parameter int BOUNCE_MAX = 4096
) (
    input  logic [LEN_W-1:0] len,
    input  logic             unreach,
    output logic [LEN_W-1:0] capped
);

    localparam logic [LEN_W-1:0] HARD_LIM   = LEN_W'(HARD_MAX);
    localparam logic [LEN_W-1:0] BOUNCE_LIM = LEN_W'(BOUNCE_MAX);

    logic [LEN_W-1:0] limit;

    always_comb begin
        limit  = unreach ? BOUNCE_LIM : HARD_LIM;
        capped = (len > limit) ? limit : len;
    end

endmodule

// File: rtl/dxq_qualifier.sv
module dxq_qualifier
    import dxq_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int BLK_BYTES  = 512,
    parameter int MAX_BLKS   = 255,
    parameter int BOUNCE_MAX = 4096,
    parameter int UNK_MIN    = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [LEN_W-1:0] in_len,
    input  logic             in_write,
    input  logic [7:0]       in_op,
    input  logic             in_fixed,
    input  logic             in_tape,
    input  logic             in_unreach,
    output logic             out_valid,
    output logic [LEN_W-1:0] out_len,
    output logic             out_cut
);

    localparam int HARD_MAX = MAX_BLKS * BLK_BYTES;

    req_attr_t        attr;
    xfer_class_e      cls;
    logic [LEN_W-1:0] allowed;
    logic [LEN_W-1:0] capped;

    assign attr = '{write: in_write, op: in_op, fixed: in_fixed,
                    tape: in_tape, unreach: in_unreach};

    dxq_classify u_classify (
        .op    (attr.op),
        .tape  (attr.tape),
        .fixed (attr.fixed),
        .cls   (cls)
    );

    dxq_policy #(
        .LEN_W     (LEN_W),
        .BLK_BYTES (BLK_BYTES),
        .UNK_MIN   (UNK_MIN)
    ) u_policy (
        .len     (in_len),
        .write   (attr.write),
        .cls     (cls),
        .allowed (allowed)
    );

    dxq_cap #(
        .LEN_W      (LEN_W),
        .HARD_MAX   (HARD_MAX),
        .BOUNCE_MAX (BOUNCE_MAX)
    ) u_cap (
        .len     (allowed),
        .unreach (attr.unreach),
        .capped  (capped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_len   <= '0;
            out_cut   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_len <= capped;
                out_cut <= (capped != in_len);
            end
        end
    end

endmodule

// File: rtl/dxq_qualifier_chk.sv
module dxq_qualifier_chk #(
    parameter int LEN_W      = 24,
    parameter int BLK_BYTES  = 512,
    parameter int MAX_BLKS   = 255,
    parameter int BOUNCE_MAX = 4096
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [LEN_W-1:0] in_len,
    input logic             in_write,
    input logic [7:0]       in_op,
    input logic             in_unreach,
    input logic             out_valid,
    input logic [LEN_W-1:0] out_len,
    input logic             out_cut
);

    localparam int BLK_LOG = $clog2(BLK_BYTES);
    localparam logic [LEN_W-1:0] HARD_LIM   = LEN_W'(MAX_BLKS * BLK_BYTES);
    localparam logic [LEN_W-1:0] BOUNCE_LIM = LEN_W'(BOUNCE_MAX);

    p_lat_on_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_lat_off_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_len) && $stable(out_cut)));
    p_write_full_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_write && !in_unreach && in_len <= HARD_LIM)
        |=> out_len == $past(in_len));
    p_partial_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_write && (|in_len[BLK_LOG-1:0])) |=> out_len == '0);
    p_byte_op_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_write && (in_op == 8'h37 || in_op == 8'h3E || in_op == 8'h3C))
        |=> out_len == '0);
    p_hard_cap_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_len <= HARD_LIM);
    p_bounce_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unreach) |=> out_len <= BOUNCE_LIM);
    p_never_grow_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_len <= $past(in_len));
    p_cut_flag_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_cut == (out_len != $past(in_len)));

endmodule

bind dxq_qualifier dxq_qualifier_chk #(
    .LEN_W      (LEN_W),
    .BLK_BYTES  (BLK_BYTES),
    .MAX_BLKS   (MAX_BLKS),
    .BOUNCE_MAX (BOUNCE_MAX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_len     (in_len),
    .in_write   (in_write),
    .in_op      (in_op),
    .in_unreach (in_unreach),
    .out_valid  (out_valid),
    .out_len    (out_len),
    .out_cut    (out_cut)
);

// File: tb/dxq_qualifier_bench.sv
module dxq_qualifier_bench;

    localparam int LEN_W = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [LEN_W-1:0] in_len = '0;
    logic             in_write = 1'b0;
    logic [7:0]       in_op = 8'h00;
    logic             in_fixed = 1'b0;
    logic             in_tape = 1'b0;
    logic             in_unreach = 1'b0;
    logic             out_valid;
    logic [LEN_W-1:0] out_len;
    logic             out_cut;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    dxq_qualifier #(.LEN_W(LEN_W)) u_dxq_qualifier (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_len(in_len),
        .in_write(in_write), .in_op(in_op), .in_fixed(in_fixed),
        .in_tape(in_tape), .in_unreach(in_unreach),
        .out_valid(out_valid), .out_len(out_len), .out_cut(out_cut)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One request; result is sampled at the falling edge after the capture edge
    task automatic request(input string req, input int len, input bit wr,
                           input logic [7:0] op, input bit fixed, input bit tape,
                           input bit unr, input int exp_len);
        in_valid   = 1'b1;
        in_len     = LEN_W'(len);
        in_write   = wr;
        in_op      = op;
        in_fixed   = fixed;
        in_tape    = tape;
        in_unreach = unr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " out_valid"}, int'(out_valid), 1);
        check({req, " out_len"}, int'(out_len), exp_len);
        check({req, " out_cut R9"}, int'(out_cut), (exp_len != len) ? 1 : 0);
    endtask

    task automatic t_reset_r10();
        check("R10 out_valid", int'(out_valid), 0);
        check("R10 out_len", int'(out_len), 0);
        check("R10 out_cut", int'(out_cut), 0);
    endtask

    task automatic t_write_r2();
        request("R2 write 1000", 1000, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b0, 1000);
        request("R2 write odd 7", 7, 1'b1, 8'h0A, 1'b0, 1'b1, 1'b0, 7);
        request("R2 write over cap", 200000, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b0, 130560);
    endtask

    task automatic t_partial_r3();
        request("R3 read 700", 700, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 0);
        request("R3 read 1536+1", 1537, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_byte_ops_r4();
        request("R4 op37", 2048, 1'b0, 8'h37, 1'b1, 1'b0, 1'b0, 0);
        request("R4 op3E", 1024, 1'b0, 8'h3E, 1'b0, 1'b0, 1'b0, 0);
        request("R4 op3C", 4096, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_block_ops_r5();
        request("R5 op08", 512, 1'b0, 8'h08, 1'b0, 1'b0, 1'b0, 512);
        request("R5 op28", 1024, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 1024);
        request("R5 opA8", 2048, 1'b0, 8'hA8, 1'b0, 1'b0, 1'b0, 2048);
        request("R5 op0F", 512, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0, 512);
        request("R5 op14", 512, 1'b0, 8'h14, 1'b0, 1'b0, 1'b0, 512);
    endtask

    task automatic t_tape_r6();
        request("R6 tape var", 1024, 1'b0, 8'h08, 1'b0, 1'b1, 1'b0, 0);
        request("R6 tape fixed", 1024, 1'b0, 8'h08, 1'b1, 1'b1, 1'b0, 1024);
        request("R6 disk nofix", 512, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b0, 512);
    endtask

    task automatic t_unknown_r7();
        request("R7 unk 512", 512, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 0);
        request("R7 unk 1024", 1024, 1'b0, 8'h12, 1'b0, 1'b0, 1'b0, 1024);
        request("R7 unk 0", 0, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_cap_r8();
        request("R8 read cap", 262144, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 130560);
        request("R8 at cap", 130560, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 130560);
        request("R8 bounce read", 8192, 1'b0, 8'h28, 1'b0, 1'b0, 1'b1, 4096);
        request("R8 bounce write", 5000, 1'b1, 8'h2A, 1'b0, 1'b0, 1'b1, 4096);
        request("R8 bounce small", 4096, 1'b0, 8'hA8, 1'b0, 1'b0, 1'b1, 4096);
    endtask

    task automatic t_hold_r1();
        request("R1 seed", 3072, 1'b0, 8'h28, 1'b0, 1'b0, 1'b0, 3072);
        in_len = LEN_W'(700);
        in_op  = 8'h37;
        repeat (3) begin
            @(negedge clk);
            check("R1 idle out_valid", int'(out_valid), 0);
            check("R1 idle out_len held", int'(out_len), 3072);
            check("R1 idle out_cut held", int'(out_cut), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r10();
        t_write_r2();
        t_partial_r3();
        t_byte_ops_r4();
        t_block_ops_r5();
        t_tape_r6();
        t_unknown_r7();
        t_cap_r8();
        t_hold_r1();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule